// File: doc/BRIEF.md
# SDRAM Bank Timing Guard

This block watches the decoded command stream that a memory controller sends to a four-bank synchronous DRAM. It keeps one timing record per bank and, every cycle, tells the controller which commands may be issued to which bank without breaking a device timing limit. The controller can use the ready flags to pick its next command. The violation output lets a bench or an on-chip monitor catch a controller that ignored the flags.

All device limits are given as picosecond parameters together with the clock period. At elaboration they are turned into whole clock counts by rounding up. The write-recovery limit is given directly in clocks. A separate interval timer raises a refresh request that stays high until an auto-refresh command is accepted.

A command that breaks a limit is reported one cycle later with a code, and it does not change any bank state. A row that stays open for the maximum active time is also reported.

Top module: `sdram_bank_timer`

## Requirements
- R1: After reset, every bank is closed and fully rested. `act_ok_o` is all ones, `rw_ok_o` and `pre_ok_o` are all zeros, `ref_ok_o` and `mrs_ok_o` are 1, `viol_o` is 0, `viol_code_o` is 0 and `refresh_due_o` is 0.
- R2: A read (code 2) or write (code 3) to a bank is legal only while that bank has an open row and at least ceil(tRCD/T) cycles have passed since its activate (2 cycles at 18 ns and 10 ns). Otherwise it is reported with code 2.
- R3: An activate (code 1) to a bank is legal only when all of these hold: the bank is closed; ceil(tRP/T) cycles have passed since its precharge; ceil(tRC/T) cycles have passed since its last activate or auto-refresh (6 cycles); and ceil(tRRD/T) cycles have passed since any activate to any bank (2 cycles). Otherwise it is reported with code 1.
- R4: A precharge (code 4) to a bank is legal only when all of these hold: the bank is open; ceil(tRAS_min/T) cycles have passed since its activate (5 cycles); and at least 2 cycles have passed since its last write. Otherwise it is reported with code 3. A precharge to a closed bank is also reported with code 3.
- R5: Auto-refresh (code 5) and mode-register write (code 6) are legal only when every bank is closed and ceil(tRP/T) cycles (2) have passed since its precharge. `ref_ok_o` and `mrs_ok_o` show this condition. A violation is reported with code 4 for refresh and code 5 for mode write.
- R6: A command that is reported as a violation has no effect on any bank state or timer.
- R7: A row kept open for ceil(tRAS_max/T) cycles (10000 cycles at 100 us) produces a violation with code 6 for exactly one cycle.
- R8: `refresh_due_o` rises ceil(tREFI/T) cycles (1560 cycles at 15.6 us) after reset or after the last accepted auto-refresh. It stays high until an auto-refresh is accepted, and it is low in the cycle after that.
- R9: `viol_o` and `viol_code_o` are registered. They describe the command offered in the previous cycle, and `viol_code_o` is 0 when there was no violation. If an illegal command and the row-open limit fall in the same cycle, the command's code is reported. A no-operation (code 0) is never a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Decoded command: 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 auto-refresh, 6 mode write |
| bank_i | input | 2 | Bank index of the command |
| act_ok_o | output | 4 | Per bank: activate is legal this cycle |
| rw_ok_o | output | 4 | Per bank: read or write is legal this cycle |
| pre_ok_o | output | 4 | Per bank: precharge is legal this cycle |
| ref_ok_o | output | 1 | Auto-refresh is legal this cycle |
| mrs_ok_o | output | 1 | Mode-register write is legal this cycle |
| viol_o | output | 1 | Previous cycle held a violation |
| viol_code_o | output | 3 | Violation code: 0 none, 1 activate, 2 read/write, 3 precharge, 4 refresh, 5 mode write, 6 row open too long |
| refresh_due_o | output | 1 | Refresh interval has elapsed |

## Verification
The assertions assume the following about the inputs:
- At most one command arrives per cycle.
- Every command has a code from 0 to 6.
- The bank index is valid in every cycle, including no-operation cycles.
- The timing parameters give at least two cycles for tRCD, tRRD and write recovery. Otherwise the one-cycle-after checks drop out through generate guards.

The stimulus holds `cmd_i` at no-operation in every cycle that does not name a command. It drives only the seven defined codes and banks 0 to 3. It changes inputs only on the falling clock edge, so each command is seen at exactly one rising edge.

// File: rtl/sdram_tc_pkg.sv
package sdram_tc_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4,
      CMD_REF = 3'd5,
      CMD_MRS = 3'd6
   } cmd_e;

   typedef enum logic [2:0] {
      VC_NONE   = 3'd0,
      VC_ACT    = 3'd1,
      VC_RW     = 3'd2,
      VC_PRE    = 3'd3,
      VC_REF    = 3'd4,
      VC_MRS    = 3'd5,
      VC_RASMAX = 3'd6
   } vcode_e;

   // Round a picosecond limit up to whole clock periods.
   function automatic int ps_to_cycles(longint lim_ps, longint period_ps);
      return int'((lim_ps + period_ps - 1) / period_ps);
   endfunction

endpackage

// File: rtl/sdram_tc_satcnt.sv
module sdram_tc_satcnt #(
   parameter int LIMIT      = 8,
   parameter bit START_FULL = 1'b1,
   parameter int W          = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   output logic [W-1:0] cnt_o
);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("sdram_tc_satcnt: LIMIT must be at least 1");
      end
      if (W < $clog2(LIMIT + 1)) begin : g_bad_width
         $error("sdram_tc_satcnt: W too small for LIMIT");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_o <= START_FULL ? W'(LIMIT) : '0;
      end else if (load_i) begin
         cnt_o <= W'(1);
      end else if (cnt_o != W'(LIMIT)) begin
         cnt_o <= cnt_o + W'(1);
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o <= W'(LIMIT)); // R3

endmodule

// File: rtl/sdram_tc_bank.sv
module sdram_tc_bank #(
   parameter int TRCD     = 2,
   parameter int TRP      = 2,
   parameter int TRAS     = 5,
   parameter int TRAS_MAX = 10000,
   parameter int TRC      = 6,
   parameter int TWR      = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_i,
   input  logic wr_i,
   input  logic pre_i,
   input  logic ref_i,
   output logic act_free_o,
   output logic rw_ok_o,
   output logic pre_ok_o,
   output logic idle_o,
   output logic ras_over_o
);

   localparam int ASAT = TRAS_MAX + 1;
   localparam int AW   = $clog2(ASAT + 1);
   localparam int PW   = $clog2(TRP + 1);
   localparam int WW   = $clog2(TWR + 1);

   generate
      if (TRAS_MAX <= TRAS || TRAS_MAX <= TRC || TRAS_MAX <= TRCD) begin : g_bad_ras
         $error("sdram_tc_bank: TRAS_MAX must exceed the other row limits");
      end
      if (TRCD < 1 || TRP < 1 || TRAS < 1 || TRC < 1 || TWR < 1) begin : g_bad_min
         $error("sdram_tc_bank: every limit must be at least one cycle");
      end
   endgenerate

   logic          open_q;
   logic [AW-1:0] a_cnt;
   logic [PW-1:0] p_cnt;
   logic [WW-1:0] w_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)     open_q <= 1'b0;
      else if (act_i) open_q <= 1'b1;
      else if (pre_i) open_q <= 1'b0;
   end

   sdram_tc_satcnt #(.LIMIT(ASAT), .START_FULL(1'b1), .W(AW)) u_since_act (
      .clk(clk), .rst_n(rst_n), .load_i(act_i | ref_i), .cnt_o(a_cnt));

   sdram_tc_satcnt #(.LIMIT(TRP), .START_FULL(1'b1), .W(PW)) u_since_pre (
      .clk(clk), .rst_n(rst_n), .load_i(pre_i), .cnt_o(p_cnt));

   sdram_tc_satcnt #(.LIMIT(TWR), .START_FULL(1'b1), .W(WW)) u_since_wr (
      .clk(clk), .rst_n(rst_n), .load_i(wr_i), .cnt_o(w_cnt));

   logic rested;
   assign rested     = (p_cnt >= PW'(TRP));
   assign idle_o     = !open_q && rested;
   assign act_free_o = idle_o && (a_cnt >= AW'(TRC));
   assign rw_ok_o    = open_q && (a_cnt >= AW'(TRCD));
   assign pre_ok_o   = open_q && (a_cnt >= AW'(TRAS)) && (w_cnt >= WW'(TWR));
   assign ras_over_o = open_q && (a_cnt == AW'(TRAS_MAX));

   AST_PRE_SHUTS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      pre_i |=> (!rw_ok_o && !pre_ok_o && !act_free_o)); // R4
   AST_RAS_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      ras_over_o |=> !ras_over_o); // R7
   AST_OPEN_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |=> !idle_o); // R5

   generate
      if (TRCD > 1) begin : g_rcd_chk
         AST_RCD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
            act_i |=> !rw_ok_o); // R2
      end
      if (TWR > 1) begin : g_wr_chk
         AST_WR_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
            wr_i |=> !pre_ok_o); // R4
      end
   endgenerate

endmodule

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer
   import sdram_tc_pkg::*;
#(
   parameter int     NUM_BANKS   = 4,
   parameter longint CLK_PS      = 10000,
   parameter longint TRCD_PS     = 18000,
   parameter longint TRRD_PS     = 12000,
   parameter longint TRP_PS      = 18000,
   parameter longint TRAS_PS     = 42000,
   parameter longint TRAS_MAX_PS = 100_000_000,
   parameter longint TRC_PS      = 60000,
   parameter int     TWR_CLK     = 2,
   parameter longint TREFI_PS    = 15_600_000,
   parameter int     BW          = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           cmd_i,
   input  logic [BW-1:0]        bank_i,
   output logic [NUM_BANKS-1:0] act_ok_o,
   output logic [NUM_BANKS-1:0] rw_ok_o,
   output logic [NUM_BANKS-1:0] pre_ok_o,
   output logic                 ref_ok_o,
   output logic                 mrs_ok_o,
   output logic                 viol_o,
   output logic [2:0]           viol_code_o,
   output logic                 refresh_due_o
);

   localparam int C_RCD   = ps_to_cycles(TRCD_PS, CLK_PS);
   localparam int C_RRD   = ps_to_cycles(TRRD_PS, CLK_PS);
   localparam int C_RP    = ps_to_cycles(TRP_PS, CLK_PS);
   localparam int C_RAS   = ps_to_cycles(TRAS_PS, CLK_PS);
   localparam int C_RASMX = ps_to_cycles(TRAS_MAX_PS, CLK_PS);
   localparam int C_RC    = ps_to_cycles(TRC_PS, CLK_PS);
   localparam int C_REFI  = ps_to_cycles(TREFI_PS, CLK_PS);
   localparam int RRW     = $clog2(C_RRD + 1);
   localparam int RFW     = $clog2(C_REFI + 1);

   generate
      if (CLK_PS <= 0) begin : g_bad_clk
         $error("sdram_bank_timer: CLK_PS must be positive");
      end
      if (NUM_BANKS < 2 || (1 << BW) != NUM_BANKS) begin : g_bad_banks
         $error("sdram_bank_timer: NUM_BANKS must be a power of two >= 2");
      end
      if (TWR_CLK < 1) begin : g_bad_wr
         $error("sdram_bank_timer: TWR_CLK must be at least 1");
      end
   endgenerate

   // Command decode and legality
   logic [NUM_BANKS-1:0] sel;
   logic [NUM_BANKS-1:0] act_free, idle, ras_over;
   logic                 all_idle, legal, accept;
   logic                 rrd_ok;
   logic [RRW-1:0]       rrd_cnt;
   logic [RFW-1:0]       refi_cnt;
   vcode_e               code_d;
   logic [2:0]           code_q;

   assign sel      = NUM_BANKS'(1) << bank_i;
   assign all_idle = &idle;
   assign rrd_ok   = (rrd_cnt >= RRW'(C_RRD));
   assign act_ok_o = act_free & {NUM_BANKS{rrd_ok}};
   assign ref_ok_o = all_idle;
   assign mrs_ok_o = all_idle;

   always_comb begin
      legal  = 1'b1;
      code_d = VC_NONE;
      unique case (cmd_i)
         CMD_ACT: begin legal = act_ok_o[bank_i]; code_d = VC_ACT; end
         CMD_RD,
         CMD_WR:  begin legal = rw_ok_o[bank_i];  code_d = VC_RW;  end
         CMD_PRE: begin legal = pre_ok_o[bank_i]; code_d = VC_PRE; end
         CMD_REF: begin legal = all_idle;         code_d = VC_REF; end
         CMD_MRS: begin legal = all_idle;         code_d = VC_MRS; end
         default: begin legal = 1'b1;             code_d = VC_NONE; end
      endcase
      if (legal) code_d = (|ras_over) ? VC_RASMAX : VC_NONE;
   end

   assign accept = legal && (cmd_i != CMD_NOP);

   logic acc_act, acc_wr, acc_pre, acc_ref;
   assign acc_act = accept && (cmd_i == CMD_ACT);
   assign acc_wr  = accept && (cmd_i == CMD_WR);
   assign acc_pre = accept && (cmd_i == CMD_PRE);
   assign acc_ref = accept && (cmd_i == CMD_REF);

   // Per-bank timing records
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      sdram_tc_bank #(
         .TRCD(C_RCD), .TRP(C_RP), .TRAS(C_RAS),
         .TRAS_MAX(C_RASMX), .TRC(C_RC), .TWR(TWR_CLK)
      ) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .act_i      (acc_act && sel[b]),
         .wr_i       (acc_wr  && sel[b]),
         .pre_i      (acc_pre && sel[b]),
         .ref_i      (acc_ref),
         .act_free_o (act_free[b]),
         .rw_ok_o    (rw_ok_o[b]),
         .pre_ok_o   (pre_ok_o[b]),
         .idle_o     (idle[b]),
         .ras_over_o (ras_over[b])
      );
   end

   // Cross-bank activate spacing
   sdram_tc_satcnt #(.LIMIT(C_RRD), .START_FULL(1'b1), .W(RRW)) u_rrd (
      .clk(clk), .rst_n(rst_n), .load_i(acc_act), .cnt_o(rrd_cnt));

   // Refresh interval timer
   sdram_tc_satcnt #(.LIMIT(C_REFI), .START_FULL(1'b0), .W(RFW)) u_refi (
      .clk(clk), .rst_n(rst_n), .load_i(acc_ref), .cnt_o(refi_cnt));

   assign refresh_due_o = (refi_cnt == RFW'(C_REFI));

   // Violation report register
   always_ff @(posedge clk) begin
      if (!rst_n) code_q <= VC_NONE;
      else        code_q <= code_d;
   end

   assign viol_code_o = code_q;
   assign viol_o      = (code_q != VC_NONE);

   AST_REF_CLEARS_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ref |=> !refresh_due_o); // R8
   AST_MODE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      mrs_ok_o |-> (pre_ok_o == '0 && rw_ok_o == '0)); // R5
   AST_BAD_ACT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_ACT && !act_ok_o[bank_i]) |=> (viol_o && viol_code_o == VC_ACT)); // R3
   AST_NOP_NOT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_NOP && ras_over == '0) |=> !viol_o); // R9

   generate
      if (C_RRD > 1) begin : g_rrd_chk
         AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            acc_act |=> (act_ok_o == '0)); // R3
      end
   endgenerate

endmodule

// File: tb/sdram_bank_timer_test.sv
`timescale 1ns/1ps
module sdram_bank_timer_test;

   localparam int PER  = 10000;
   localparam int RMAX = (100_000_000 + PER - 1) / PER;
   localparam int REFI = (15_600_000 + PER - 1) / PER;

   localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                          PRE = 3'd4, REF = 3'd5, MRS = 3'd6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cmd = NOP;
   logic [1:0] bank = 2'd0;
   logic [3:0] act_ok, rw_ok, pre_ok;
   logic       ref_ok, mrs_ok, viol, due;
   logic [2:0] vcode;

   always #5 clk = ~clk;

   sdram_bank_timer uut (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank),
      .act_ok_o(act_ok), .rw_ok_o(rw_ok), .pre_ok_o(pre_ok),
      .ref_ok_o(ref_ok), .mrs_ok_o(mrs_ok), .viol_o(viol),
      .viol_code_o(vcode), .refresh_due_o(due));

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;
   int    q_code[$];
   string q_req[$];

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   // Driver: every cycle pushes one expected report (default nop, code 0)
   task automatic nx();
      @(negedge clk);
      cmd  = NOP;
      bank = 2'd0;
      q_code.push_back(0);
      q_req.push_back("R9");
   endtask

   task automatic drive(input logic [2:0] c, input int b, input int exp, input string req);
      cmd  = c;
      bank = 2'(b);
      q_code[q_code.size()-1] = exp;
      q_req[q_req.size()-1]   = req;
   endtask

   // Monitor: compares the registered report after each edge
   always @(posedge clk) begin
      #1;
      if (q_code.size() > 0) begin
         int    e;
         string r;
         e = q_code.pop_front();
         r = q_req.pop_front();
         chk(r, {28'd0, viol, vcode}, {28'd0, (e != 0), 3'(e)});
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1", act_ok, 4'hF);
      chk("R1", rw_ok, 4'h0);
      chk("R1", pre_ok, 4'h0);
      chk("R1", ref_ok, 1);
      chk("R1", mrs_ok, 1);
      chk("R1", {viol, vcode}, 0);
      chk("R1", due, 0);

      nx(); chk("R3", act_ok[0], 1); drive(ACT, 0, 0, "R3");
      nx(); chk("R2", rw_ok[0], 0); chk("R3", act_ok[1], 0); drive(RD, 0, 2, "R2");
      nx(); chk("R2", rw_ok[0], 1); chk("R3", act_ok[1], 1); drive(ACT, 1, 0, "R3");
      nx(); drive(WR, 0, 0, "R2");
      nx(); chk("R4", pre_ok[0], 0); drive(PRE, 0, 3, "R4");
      nx(); chk("R6", rw_ok[0], 1); drive(WR, 0, 0, "R2");
      nx(); chk("R4", pre_ok[0], 0); chk("R4", pre_ok[1], 0);
      nx(); chk("R4", pre_ok[0], 1); chk("R4", pre_ok[1], 1); drive(PRE, 0, 0, "R4");
      nx(); chk("R3", act_ok[0], 0); chk("R4", rw_ok[0], 0); drive(ACT, 0, 1, "R3");
      nx(); chk("R3", act_ok[0], 1); chk("R5", mrs_ok, 0); chk("R5", ref_ok, 0);
            drive(MRS, 0, 5, "R5");
      nx(); drive(REF, 0, 4, "R5");
      nx(); chk("R6", rw_ok[1], 1); drive(PRE, 1, 0, "R4");
      nx(); chk("R5", ref_ok, 0); drive(PRE, 3, 3, "R4");
      nx(); chk("R5", ref_ok, 1); chk("R5", mrs_ok, 1); drive(MRS, 0, 0, "R5");
      nx(); drive(REF, 0, 0, "R5");
      for (int j = 1; j <= 6; j++) begin
         nx();
         if (j == 1) chk("R8", due, 0);
         if (j == 5) chk("R3", act_ok[2], 0);
         if (j == 6) begin chk("R3", act_ok[2], 1); drive(ACT, 2, 0, "R3"); end
      end
      // R7 row held open to the maximum active time
      for (int j = 1; j <= RMAX + 1; j++) begin
         nx();
         if (j == RMAX) drive(NOP, 0, 6, "R7");
      end
      nx(); chk("R7", pre_ok[2], 1); drive(PRE, 2, 0, "R7");
      nx();
      nx(); chk("R8", due, 1); chk("R5", ref_ok, 1); drive(REF, 0, 0, "R8");
      for (int j = 1; j <= REFI; j++) begin
         nx();
         if (j == 1 || j == REFI - 1) chk("R8", due, 0);
         if (j == REFI) chk("R8", due, 1);
      end
      nx(); chk("R8", due, 1);
      nx(); nx();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule